// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is the target (slave) side of a two-wire serial bus. It watches the clock and data lines through synchronizers running on the system clock and finds START, repeated START and STOP conditions. It answers a 7-bit address whose upper bits are a build-time parameter and whose lower bits come from strap pins. The block never drives a line high. Each line has a drive-low enable output, and the resolved line level comes back in as an input.

In a write transfer, the first data byte sets an internal byte pointer. Each later byte is handed to local logic as a one-cycle strobe that carries the pointer and the data, and the pointer then advances. In a read transfer, the block asks local logic for the byte at the pointer and shifts it out MSB first, and the pointer then advances. Reading continues while the controller acknowledges and ends at the first NACK.

After the acknowledge clock of every byte, the block holds the clock line low for as long as local logic reports that it is not ready. The controller therefore waits for slow local logic instead of losing data.

Top module: `i2c_stretch_target`

## Requirements
- R1: While reset is asserted and after it is released, both drive-low enables are 0 and `wr_valid` and `rd_req` are 0.
- R2: The first byte after a START is taken MSB first as a 7-bit address and then a direction bit (0 = write, 1 = read). The address is matched against {ADDR_HI, strap_addr}. On a match, the target pulls SDA low for the whole ninth clock as an ACK.
- R3: On an address mismatch, the target gives no ACK and raises no strobe until the next START.
- R4: In a write, every byte is ACKed. The first data byte loads the pointer. Each later byte raises `wr_valid` for one cycle with `wr_ptr` equal to the pointer and `wr_data` equal to the byte, and the pointer then advances by one.
- R5: A repeated START is accepted in any state and is followed by a new address byte. In a read, each byte is `rd_data` sampled at pointer `rd_ptr` and sent MSB first, and the pointer advances by one after each byte. The pointer keeps its value from one transfer to the next.
- R6: A NACK from the controller after a read byte ends the transfer, and SDA stays released until the next START.
- R7: After the acknowledge clock of each byte, SCL is held low while `local_ready` is 0 and is released once `local_ready` is 1. When `local_ready` is already 1, the hold lasts only one cycle.
- R8: After a STOP the target is idle, and bytes clocked without a new START receive no ACK.
- R9: The target changes its SDA drive only while SCL is low. It never releases SDA while it holds SCL low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| strap_addr | input | STRAP_W | Low address bits from strap pins |
| local_ready | input | 1 | Local logic can take or give the next byte |
| wr_valid | output | 1 | One-cycle write strobe |
| wr_ptr | output | PTR_W | Pointer of the written byte |
| wr_data | output | 8 | Written byte |
| rd_req | output | 1 | Read byte wanted at rd_ptr |
| rd_ptr | output | PTR_W | Pointer of the byte to read |
| rd_data | input | 8 | Byte supplied by local logic |

## Verification
If the bit counter or the state register goes wrong, the fault shows on SDA within one bus clock. The ACK slot either does not go low or goes low one bit early or late, and a read byte comes out shifted. A wrong pointer shows at the next `wr_valid` strobe, or as wrong data in the next read byte, so a write-then-read sequence exposes it within a few bytes. A faulty stretch path shows in the next bit period: either SCL stays low after `local_ready` rises, or SCL is released while `local_ready` is still low.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int TGT_ADDR_W = 7;
  localparam int BYTE_BITS  = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_HOLD,
    ST_RD_BYTE,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d};
    end
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_s,
  input  logic                  sda_s,
  input  logic [TGT_ADDR_W-1:0] own_addr,
  input  logic                  local_ready,
  input  logic [BYTE_BITS-1:0]  rd_data,
  output logic                  hold_scl,
  output logic                  sda_low,
  output logic                  wr_valid,
  output logic [PTR_W-1:0]      wr_ptr,
  output logic [BYTE_BITS-1:0]  wr_data,
  output logic                  rd_req,
  output logic [PTR_W-1:0]      rd_ptr
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

  tgt_state_e           state_q, state_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic [BYTE_BITS-1:0] sh_q, sh_n;
  logic                 dir_rd_q, dir_rd_n;
  logic                 ack_rx_q, ack_rx_n;
  logic                 sda_low_q, sda_low_n;
  logic [PTR_W-1:0]     ptr_q, ptr_n;
  logic                 ptr_set_q, ptr_set_n;
  logic                 wr_valid_q, wr_valid_n;
  logic [PTR_W-1:0]     wr_ptr_q, wr_ptr_n;
  logic [BYTE_BITS-1:0] wr_data_q, wr_data_n;
  logic                 scl_q, sda_q;

  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

  always_comb begin
    state_n    = state_q;
    cnt_n      = cnt_q;
    sh_n       = sh_q;
    dir_rd_n   = dir_rd_q;
    ack_rx_n   = ack_rx_q;
    sda_low_n  = sda_low_q;
    ptr_n      = ptr_q;
    ptr_set_n  = ptr_set_q;
    wr_valid_n = 1'b0;
    wr_ptr_n   = wr_ptr_q;
    wr_data_n  = wr_data_q;
    if (stop_ev) begin
      state_n   = ST_IDLE;
      sda_low_n = 1'b0;
    end else if (start_ev) begin
      state_n   = ST_ADDR;
      cnt_n     = '0;
      ptr_set_n = 1'b0;
      sda_low_n = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_BITS-2:0], sda_s};
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (sh_q[BYTE_BITS-1:1] == own_addr) begin
              state_n   = ST_ADDR_ACK;
              sda_low_n = 1'b1;
              dir_rd_n  = sh_q[0];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            sda_low_n = 1'b0;
            state_n   = ST_HOLD;
            cnt_n     = '0;
          end
        end
        ST_HOLD: begin
          if (local_ready) begin
            cnt_n = '0;
            if (dir_rd_q) begin
              sh_n      = rd_data;
              sda_low_n = ~rd_data[BYTE_BITS-1];
              ptr_n     = ptr_q + PTR_W'(1);
              state_n   = ST_RD_BYTE;
            end else begin
              state_n = ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise) begin
            sh_n  = {sh_q[BYTE_BITS-2:0], sda_s};
            cnt_n = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            state_n   = ST_WR_ACK;
            sda_low_n = 1'b1;
            if (!ptr_set_q) begin
              ptr_n     = PTR_W'(sh_q);
              ptr_set_n = 1'b1;
            end else begin
              wr_valid_n = 1'b1;
              wr_ptr_n   = ptr_q;
              wr_data_n  = sh_q;
              ptr_n      = ptr_q + PTR_W'(1);
            end
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            cnt_n = cnt_q + CNT_W'(1);
            if (cnt_q == CNT_LAST) begin
              state_n   = ST_RD_ACK;
              sda_low_n = 1'b0;
            end else begin
              sh_n      = {sh_q[BYTE_BITS-2:0], 1'b0};
              sda_low_n = ~sh_q[BYTE_BITS-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            ack_rx_n = ~sda_s;
          end else if (scl_fall) begin
            state_n = ack_rx_q ? ST_HOLD : ST_IDLE;
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      dir_rd_q   <= 1'b0;
      ack_rx_q   <= 1'b0;
      sda_low_q  <= 1'b0;
      ptr_q      <= '0;
      ptr_set_q  <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_ptr_q   <= '0;
      wr_data_q  <= '0;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
    end else begin
      state_q    <= state_n;
      cnt_q      <= cnt_n;
      sh_q       <= sh_n;
      dir_rd_q   <= dir_rd_n;
      ack_rx_q   <= ack_rx_n;
      sda_low_q  <= sda_low_n;
      ptr_q      <= ptr_n;
      ptr_set_q  <= ptr_set_n;
      wr_valid_q <= wr_valid_n;
      wr_ptr_q   <= wr_ptr_n;
      wr_data_q  <= wr_data_n;
      scl_q      <= scl_s;
      sda_q      <= sda_s;
    end
  end

  assign hold_scl = (state_q == ST_HOLD);
  assign rd_req   = (state_q == ST_HOLD) & dir_rd_q;
  assign sda_low  = sda_low_q;
  assign wr_valid = wr_valid_q;
  assign wr_ptr   = wr_ptr_q;
  assign wr_data  = wr_data_q;
  assign rd_ptr   = ptr_q;
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
  import i2cs_pkg::*;
#(
  parameter int   STRAP_W     = 2,
  parameter int   PTR_W       = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic [TGT_ADDR_W-STRAP_W-1:0] ADDR_HI = 5'b10100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_in,
  input  logic                 sda_in,
  output logic                 scl_drive_low,
  output logic                 sda_drive_low,
  input  logic [STRAP_W-1:0]   strap_addr,
  input  logic                 local_ready,
  output logic                 wr_valid,
  output logic [PTR_W-1:0]     wr_ptr,
  output logic [BYTE_BITS-1:0] wr_data,
  output logic                 rd_req,
  output logic [PTR_W-1:0]     rd_ptr,
  input  logic [BYTE_BITS-1:0] rd_data
);
  logic [1:0] raw_lines, synced_lines;
  assign raw_lines = {sda_in, scl_in};

  for (genvar gi = 0; gi < 2; gi++) begin : g_sync
    i2cs_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_lines[gi]),
      .q    (synced_lines[gi])
    );
  end

  logic [TGT_ADDR_W-1:0] own_addr;
  assign own_addr = {ADDR_HI, strap_addr};

  i2cs_engine #(.PTR_W(PTR_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (synced_lines[0]),
    .sda_s      (synced_lines[1]),
    .own_addr   (own_addr),
    .local_ready(local_ready),
    .rd_data    (rd_data),
    .hold_scl   (scl_drive_low),
    .sda_low    (sda_drive_low),
    .wr_valid   (wr_valid),
    .wr_ptr     (wr_ptr),
    .wr_data    (wr_data),
    .rd_req     (rd_req),
    .rd_ptr     (rd_ptr)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic local_ready,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic wr_valid
);
  assert_sda_rise_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_in);

  assert_sda_fall_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> !scl_in);

  assert_hold_sda_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> !sda_drive_low);

  assert_stretch_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && !local_ready) |=> scl_drive_low);

  assert_stretch_end_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> $past(local_ready));

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
endmodule

bind i2c_stretch_target i2cs_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_in       (scl_in),
  .local_ready  (local_ready),
  .scl_drive_low(scl_drive_low),
  .sda_drive_low(sda_drive_low),
  .wr_valid     (wr_valid)
);

// File: tb/i2c_stretch_target_test.sv
`timescale 1ns/1ps
module i2c_stretch_target_test;
  localparam int HP = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       m_scl_low, m_sda_low;
  logic       scl_drive_low, sda_drive_low;
  logic [1:0] strap;
  logic       local_ready;
  logic       wr_valid, rd_req;
  logic [7:0] wr_ptr, wr_data, rd_ptr, rd_data;
  logic       scl_line, sda_line;

  assign scl_line = !(m_scl_low || scl_drive_low);
  assign sda_line = !(m_sda_low || sda_drive_low);

  logic [7:0] mem   [256];
  logic [7:0] model [256];
  assign rd_data = mem[rd_ptr];

  i2c_stretch_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .strap_addr(strap), .local_ready(local_ready),
    .wr_valid(wr_valid), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_ptr(rd_ptr), .rd_data(rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int wr_seen  = 0;
  int stretch_max = 0;
  bit done = 0;

  typedef struct packed { logic [7:0] p; logic [7:0] d; } wr_item_t;
  wr_item_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_wr(input logic [7:0] p, input logic [7:0] d);
    exp_q.push_back({p, d});
    model[p] = d;
  endtask

  task automatic release_scl();
    int w = 0;
    m_scl_low = 1'b0;
    @(negedge clk);
    while (!scl_line) begin
      w++;
      @(negedge clk);
    end
    if (w > stretch_max) stretch_max = w;
  endtask

  task automatic send_bit(input bit b);
    m_sda_low = !b;
    idle(HP);
    release_scl();
    idle(HP);
    m_scl_low = 1'b1;
    idle(HP);
  endtask

  task automatic read_bit(output bit b);
    bit b2;
    m_sda_low = 1'b0;
    idle(HP);
    release_scl();
    idle(HP / 2);
    b = sda_line;
    idle(HP / 2);
    b2 = sda_line;
    check(b == b2, "R9 sda stable while scl high", b2, b);
    m_scl_low = 1'b1;
    idle(HP);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(a);
    acked = !a;
  endtask

  task automatic read_byte(input bit ack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b);
      v[i] = b;
    end
    send_bit(!ack);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b1; idle(HP);
    m_scl_low = 1'b1; idle(HP);
  endtask

  task automatic bus_rstart();
    m_sda_low = 1'b0; idle(HP);
    release_scl();    idle(HP);
    m_sda_low = 1'b1; idle(HP);
    m_scl_low = 1'b1; idle(HP);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; idle(HP);
    release_scl();    idle(HP);
    m_sda_low = 1'b0; idle(HP);
  endtask

  // monitor: pops expected writes as the design strobes them, acts as local storage
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      wr_seen++;
      mem[wr_ptr] = wr_data;
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected write strobe", {wr_ptr, wr_data}, 0);
      end else begin
        wr_item_t e;
        e = exp_q.pop_front();
        check(wr_ptr == e.p, "R4 wr_ptr", wr_ptr, e.p);
        check(wr_data == e.d, "R4 wr_data", wr_data, e.d);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    int seen0;
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i) ^ 8'h5A;
      model[i] = 8'(i) ^ 8'h5A;
    end
    rst_n = 1'b0; m_scl_low = 1'b0; m_sda_low = 1'b0;
    strap = 2'b01; local_ready = 1'b1;
    idle(5);
    check(!scl_drive_low && !sda_drive_low, "R1 lines released in reset",
          {scl_drive_low, sda_drive_low}, 0);
    check(!wr_valid && !rd_req, "R1 strobes low in reset", {wr_valid, rd_req}, 0);
    rst_n = 1'b1;
    idle(5);
    check(!scl_drive_low && !sda_drive_low, "R1 lines released after reset",
          {scl_drive_low, sda_drive_low}, 0);

    // R2 / R4: write with address 0x51 (byte 0xA2)
    stretch_max = 0;
    bus_start();
    send_byte(8'hA2, ack); check(ack, "R2 address ack", ack, 1);
    send_byte(8'h10, ack); check(ack, "R4 pointer byte ack", ack, 1);
    exp_wr(8'h10, 8'hA5);
    send_byte(8'hA5, ack); check(ack, "R4 data ack", ack, 1);
    exp_wr(8'h11, 8'h3C);
    send_byte(8'h3C, ack); check(ack, "R4 data ack", ack, 1);
    bus_stop();
    check(wr_seen == 2, "R4 write count", wr_seen, 2);
    check(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    check(stretch_max < 10, "R7 no long stretch when ready", stretch_max, 0);

    // R5 / R6: set pointer, repeated start, read back
    bus_start();
    send_byte(8'hA2, ack);
    send_byte(8'h10, ack);
    bus_rstart();
    send_byte(8'hA3, ack); check(ack, "R5 read address ack after repeated start", ack, 1);
    read_byte(1'b1, v); check(v == model[8'h10], "R5 read byte 0", v, model[8'h10]);
    read_byte(1'b0, v); check(v == model[8'h11], "R5 read byte 1", v, model[8'h11]);
    idle(5);
    check(!sda_drive_low, "R6 sda released after nack", sda_drive_low, 0);
    bus_stop();

    // R5: pointer carried over and incremented (now 0x12)
    bus_start();
    send_byte(8'hA3, ack);
    read_byte(1'b1, v); check(v == model[8'h12], "R5 pointer increments", v, model[8'h12]);
    read_byte(1'b0, v); check(v == model[8'h13], "R5 pointer increments", v, model[8'h13]);
    bus_stop();

    // R3: mismatched address 0x52
    seen0 = wr_seen;
    bus_start();
    send_byte(8'hA4, ack); check(!ack, "R3 no ack on mismatch", ack, 0);
    send_byte(8'h77, ack); check(!ack, "R3 ignored after mismatch", ack, 0);
    send_byte(8'h66, ack); check(!ack, "R3 ignored after mismatch", ack, 0);
    bus_stop();
    check(wr_seen == seen0, "R3 no write strobe", wr_seen, seen0);

    // R2: strap pins select low address bits
    strap = 2'b10;
    bus_start();
    send_byte(8'hA4, ack); check(ack, "R2 strap address ack", ack, 1);
    send_byte(8'h30, ack);
    exp_wr(8'h30, 8'h99);
    send_byte(8'h99, ack);
    bus_stop();
    bus_start();
    send_byte(8'hA2, ack); check(!ack, "R2 old strap address rejected", ack, 0);
    bus_stop();
    strap = 2'b01;

    // R8: bytes without START after STOP
    m_scl_low = 1'b1; idle(HP);
    send_byte(8'hA2, ack); check(!ack, "R8 no ack without start", ack, 0);
    bus_stop();

    // R7: stretch after address byte while local logic is busy
    stretch_max = 0;
    local_ready = 1'b0;
    fork
      begin
        idle(1000);
        check(scl_drive_low && !scl_line, "R7 scl held low while not ready",
              {scl_drive_low, scl_line}, 2);
        local_ready = 1'b1;
      end
    join_none
    bus_start();
    send_byte(8'hA2, ack); check(ack, "R7 address ack", ack, 1);
    send_byte(8'h40, ack);
    exp_wr(8'h40, 8'h5E);
    send_byte(8'h5E, ack); check(ack, "R7 data ack after stretch", ack, 1);
    bus_stop();
    check(stretch_max > 200, "R7 controller waited for stretch", stretch_max, 200);
    check(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);

    idle(20);
    done = 1;
    report();
    $finish;
  end
endmodule